// File: doc/BRIEF.md
# CAM Command-Port Instruction Decoder

This block sits behind the 16-bit command/data port of a content-addressable memory. Each clock in which the active-low enable is low counts as one bus cycle. The command-select and write strobes classify that cycle as a command read, a command write, a data read or a data write. Command writes are normally decoded as instructions, and command reads normally return the status register.

Two instructions set persistent selections, and these hold until they are replaced or the block is reset. One picks the source used for data reads. The other picks the destination used for data writes, together with a mask choice and a validity setting. When either one names a memory location and carries an address flag, the decoder takes the next command write as a 12-bit address. It then applies the selection and asks the address register to load that address.

A third instruction arms a one-shot override. The next command read or write is then routed to a named register instead of the status register or the instruction decoder, and the port then goes back to normal behaviour by itself. Writing zero to the control register through the override produces a software reset.

Top module: `cam_cmd_decoder`

## Requirements
- R1: After reset the source and destination selections are 0 (comparand), the mask and validity selections are 0, no override or address wait is pending, and `ar_load` and `soft_rst` are low.
- R2: When no override is pending, a command read (`en_n`=0, `cmd_n`=0, `wr_n`=1) raises `stat_rd` in that same cycle, with `reg_rd`, `reg_wr` and `id_oe` low.
- R3: A command write of pattern 0000 f000 0000 0sss sets `src_sel` to sss from the next cycle. When f=0, or when sss is not 3 (memory location), this happens without waiting. The value then holds through data cycles, command reads and unrelated instructions.
- R4: A command write of pattern 0000 f001 mmdd dvvv sets `dst_sel`=ddd, `dst_mask`=mm and `dst_valid`=vvv from the next cycle. This happens immediately unless f=1 and ddd=3.
- R5: With f=1 and code 3, the selection is deferred. The next command write that reaches the decoder supplies the address in bits 11:0, and the following cycle shows the new selection with `ar_load` high for exactly one cycle and `ar_value` equal to that address. Data cycles and command reads in between do not consume the wait. That address write is never decoded as an instruction.
- R6: A command write of pattern 0000 0010 00dd d000 arms an override. Data cycles leave it pending. The next command cycle is routed to register ddd on `reg_code`: a read raises `reg_rd` instead of `stat_rd`, and a write raises `reg_wr` and is not decoded. Later command cycles return to normal.
- R7: An override write to register code 3 (next-free), 4 (source-state) or 5 (destination-state) leaves `reg_wr` low, still consumes the override, and changes no selection.
- R8: An override read of register code 4 raises `id_oe`, and `id_value` carries the parameter `DEV_ID` for bits 15:4.
- R9: An override write of 0000H to register code 0 (control) pulses `soft_rst` for one cycle and returns every selection to its R1 value. Any other value only raises `reg_wr`.
- R10: Cycles with `en_n` high, data cycles (`cmd_n` high), and command writes matching none of the three patterns change no selection and arm nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low cycle enable |
| cmd_n | input | 1 | Low for a command cycle, high for a data cycle |
| wr_n | input | 1 | Low for a write, high for a read |
| bus | input | 16 | Command/data word |
| src_sel | output | 3 | Persistent data-read source code |
| dst_sel | output | 3 | Persistent data-write destination code |
| dst_mask | output | 2 | Mask register choice for data writes |
| dst_valid | output | 3 | Validity setting for memory-location writes |
| ar_load | output | 1 | One-cycle request to load the address register |
| ar_value | output | AW | Address to load |
| stat_rd | output | 1 | Current command read returns status |
| reg_rd | output | 1 | Current command read targets `reg_code` |
| reg_wr | output | 1 | Current command write targets `reg_code` |
| reg_code | output | 3 | Register named by the pending override |
| id_oe | output | 1 | Drive the device identifier on bits 15:4 |
| id_value | output | 12 | Device identifier |
| soft_rst | output | 1 | One-cycle software reset request |

## Verification
The bench builds the block with the default 12-bit address width and with `DEV_ID` set to 12'hC47 rather than the default. This means the identifier check cannot pass on a value that is only right by chance. The full address width lets the all-ones address 12'hFFF reach `ar_value`, which shows that the upper command-word bits are dropped. Because the width matches the opcode's address field, an address write whose value looks like an override instruction can be used to show that a pending address wait takes priority over instruction decoding.

// File: rtl/camdec_pkg.sv
package camdec_pkg;

    localparam int CMD_W = 16;
    localparam int ID_W  = 12;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_SRC  = 2'd1,
        OP_DST  = 2'd2,
        OP_OVR  = 2'd3
    } op_kind_e;

    localparam logic [2:0] SEL_CMP = 3'd0;
    localparam logic [2:0] SEL_MEM = 3'd3;

    localparam logic [2:0] RG_CTL  = 3'd0;
    localparam logic [2:0] RG_FREE = 3'd3;
    localparam logic [2:0] RG_PSRC = 3'd4;
    localparam logic [2:0] RG_PDST = 3'd5;

    typedef struct packed {
        op_kind_e   kind;
        logic       aflag;
        logic [2:0] code;
        logic [1:0] mask;
        logic [2:0] valid;
    } op_t;

    typedef struct packed {
        logic [2:0] sel;
        logic [1:0] mask;
        logic [2:0] valid;
    } dst_t;

    function automatic logic reg_writable(input logic [2:0] c);
        return !((c == RG_FREE) || (c == RG_PSRC) || (c == RG_PDST));
    endfunction

endpackage

// File: rtl/camdec_opdec.sv
module camdec_opdec
    import camdec_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output op_t              op
);

    always_comb begin
        op = '0;
        op.kind = OP_NONE;
        if (word[15:12] == 4'h0) begin
            case (word[10:8])
                3'b000: begin
                    if (word[7:3] == 5'd0) begin
                        op.kind  = OP_SRC;
                        op.aflag = word[11];
                        op.code  = word[2:0];
                    end
                end
                3'b001: begin
                    op.kind  = OP_DST;
                    op.aflag = word[11];
                    op.mask  = word[7:6];
                    op.code  = word[5:3];
                    op.valid = word[2:0];
                end
                3'b010: begin
                    if (!word[11] && (word[7:6] == 2'b00) && (word[2:0] == 3'b000)) begin
                        op.kind = OP_OVR;
                        op.code = word[5:3];
                    end
                end
                default: op.kind = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/camdec_persist.sv
module camdec_persist
    import camdec_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          srst,
    input  logic          port_wr,
    input  op_t           op,
    input  logic [AW-1:0] addr_in,
    output logic [2:0]    src_sel,
    output dst_t          dst,
    output logic          ar_load,
    output logic [AW-1:0] ar_value,
    output logic          waiting
);

    logic [2:0]    src_q;
    dst_t          dst_q;
    logic          wait_q;
    logic          wait_dst_q;
    logic [2:0]    held_src_q;
    dst_t          held_dst_q;
    logic          ar_load_q;
    logic [AW-1:0] ar_val_q;
    logic          defer;

    assign defer = op.aflag && (op.code == SEL_MEM);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            src_q      <= SEL_CMP;
            dst_q      <= '0;
            wait_q     <= 1'b0;
            wait_dst_q <= 1'b0;
            held_src_q <= SEL_CMP;
            held_dst_q <= '0;
            ar_load_q  <= 1'b0;
            ar_val_q   <= '0;
        end else begin
            ar_load_q <= 1'b0;
            if (port_wr) begin
                if (wait_q) begin
                    if (wait_dst_q) dst_q <= held_dst_q;
                    else            src_q <= held_src_q;
                    ar_load_q <= 1'b1;
                    ar_val_q  <= addr_in;
                    wait_q    <= 1'b0;
                end else begin
                    case (op.kind)
                        OP_SRC: begin
                            if (defer) begin
                                wait_q     <= 1'b1;
                                wait_dst_q <= 1'b0;
                                held_src_q <= op.code;
                            end else begin
                                src_q <= op.code;
                            end
                        end
                        OP_DST: begin
                            if (defer) begin
                                wait_q     <= 1'b1;
                                wait_dst_q <= 1'b1;
                                held_dst_q <= '{sel: op.code, mask: op.mask, valid: op.valid};
                            end else begin
                                dst_q <= '{sel: op.code, mask: op.mask, valid: op.valid};
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign src_sel  = src_q;
    assign dst      = dst_q;
    assign ar_load  = ar_load_q;
    assign ar_value = ar_val_q;
    assign waiting  = wait_q;

    // R5: the address request lasts a single cycle
    a_r5_load_pulse: assert property (@(posedge clk) disable iff (rst)
        ar_load |=> !ar_load);

    // R5: a pending wait keeps the selections until its address write arrives
    a_r5_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (wait_q && !port_wr && !srst) |=> (wait_q && $stable(src_q) && $stable(dst_q)));

endmodule

// File: rtl/camdec_override.sv
module camdec_override
    import camdec_pkg::*;
#(
    parameter logic [ID_W-1:0] DEV_ID = 12'h364
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic             cmd_rd,
    input  logic [CMD_W-1:0] word,
    input  logic             waiting,
    input  op_kind_e         op_kind,
    input  logic [2:0]       op_code,
    output logic             pend,
    output logic             stat_rd,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [2:0]       reg_code,
    output logic             id_oe,
    output logic [ID_W-1:0]  id_value,
    output logic             srst_now,
    output logic             soft_rst
);

    logic       pend_q;
    logic [2:0] code_q;
    logic       srst_q;

    always_comb begin
        stat_rd  = cmd_rd && !pend_q;
        reg_rd   = cmd_rd && pend_q;
        reg_wr   = cmd_wr && pend_q && reg_writable(code_q);
        reg_code = pend_q ? code_q : 3'd0;
        id_oe    = reg_rd && (code_q == RG_PSRC);
        srst_now = cmd_wr && pend_q && (code_q == RG_CTL) && (word == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            code_q <= 3'd0;
            srst_q <= 1'b0;
        end else begin
            srst_q <= srst_now;
            if (pend_q && (cmd_wr || cmd_rd)) begin
                pend_q <= 1'b0;
            end else if (cmd_wr && !waiting && (op_kind == OP_OVR)) begin
                pend_q <= 1'b1;
                code_q <= op_code;
            end
        end
    end

    assign pend     = pend_q;
    assign id_value = DEV_ID;
    assign soft_rst = srst_q;

    // R6: a routed command cycle is never followed directly by another one
    a_r6_one_shot: assert property (@(posedge clk) disable iff (rst)
        (reg_rd || reg_wr) |=> !(reg_rd || reg_wr));

endmodule

// File: rtl/cam_cmd_decoder.sv
module cam_cmd_decoder
    import camdec_pkg::*;
#(
    parameter int               AW     = 12,
    parameter logic [ID_W-1:0]  DEV_ID = 12'h364
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_n,
    input  logic             cmd_n,
    input  logic             wr_n,
    input  logic [CMD_W-1:0] bus,
    output logic [2:0]       src_sel,
    output logic [2:0]       dst_sel,
    output logic [1:0]       dst_mask,
    output logic [2:0]       dst_valid,
    output logic             ar_load,
    output logic [AW-1:0]    ar_value,
    output logic             stat_rd,
    output logic             reg_rd,
    output logic             reg_wr,
    output logic [2:0]       reg_code,
    output logic             id_oe,
    output logic [ID_W-1:0]  id_value,
    output logic             soft_rst
);

    logic cmd_cyc, cmd_wr, cmd_rd, port_wr;
    logic pend, waiting, srst_now;
    op_t  op;
    dst_t dst;

    assign cmd_cyc = !en_n && !cmd_n;
    assign cmd_wr  = cmd_cyc && !wr_n;
    assign cmd_rd  = cmd_cyc && wr_n;
    assign port_wr = cmd_wr && !pend;

    camdec_opdec u_dec (
        .word (bus),
        .op   (op)
    );

    camdec_override #(.DEV_ID(DEV_ID)) u_ovr (
        .clk      (clk),
        .rst      (rst),
        .cmd_wr   (cmd_wr),
        .cmd_rd   (cmd_rd),
        .word     (bus),
        .waiting  (waiting),
        .op_kind  (op.kind),
        .op_code  (op.code),
        .pend     (pend),
        .stat_rd  (stat_rd),
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_code (reg_code),
        .id_oe    (id_oe),
        .id_value (id_value),
        .srst_now (srst_now),
        .soft_rst (soft_rst)
    );

    camdec_persist #(.AW(AW)) u_sel (
        .clk      (clk),
        .rst      (rst),
        .srst     (srst_now),
        .port_wr  (port_wr),
        .op       (op),
        .addr_in  (bus[AW-1:0]),
        .src_sel  (src_sel),
        .dst      (dst),
        .ar_load  (ar_load),
        .ar_value (ar_value),
        .waiting  (waiting)
    );

    assign dst_sel   = dst.sel;
    assign dst_mask  = dst.mask;
    assign dst_valid = dst.valid;

    // R9: a software reset pulse shows every selection at its reset value
    a_r9_soft_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |-> (src_sel == SEL_CMP && dst_sel == 3'd0 && dst_mask == 2'd0 && dst_valid == 3'd0));

    // R5: an address load only accompanies a memory-location selection
    a_r5_load_mem: assert property (@(posedge clk) disable iff (rst)
        ar_load |-> (src_sel == SEL_MEM || dst_sel == SEL_MEM));

    // R2: status and override routing never coincide
    a_r2_status_excl: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (!reg_rd && !reg_wr && !id_oe));

endmodule

// File: tb/cam_cmd_decoder_test.sv
module cam_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst, en_n, cmd_n, wr_n;
    logic [15:0] bus;
    logic [2:0]  src_sel, dst_sel, dst_valid, reg_code;
    logic [1:0]  dst_mask;
    logic        ar_load, stat_rd, reg_rd, reg_wr, id_oe, soft_rst;
    logic [11:0] ar_value, id_value;

    always #10 clk = ~clk;

    cam_cmd_decoder #(.AW(12), .DEV_ID(12'hC47)) uut (
        .clk(clk), .rst(rst), .en_n(en_n), .cmd_n(cmd_n), .wr_n(wr_n), .bus(bus),
        .src_sel(src_sel), .dst_sel(dst_sel), .dst_mask(dst_mask), .dst_valid(dst_valid),
        .ar_load(ar_load), .ar_value(ar_value), .stat_rd(stat_rd), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_code(reg_code), .id_oe(id_oe), .id_value(id_value),
        .soft_rst(soft_rst)
    );

    typedef struct {
        int    src, dst, msk, vld, arl, arv, srs;
        string req;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;

    int m_src, m_dst, m_msk, m_vld, m_arv;
    int m_wait, m_wdst, m_hsrc, m_hdst, m_hmsk, m_hvld, m_pend, m_code;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_src = 0; m_dst = 0; m_msk = 0; m_vld = 0; m_arv = 0;
        m_wait = 0; m_wdst = 0; m_hsrc = 0; m_hdst = 0; m_hmsk = 0; m_hvld = 0;
        m_pend = 0; m_code = 0;
    endtask

    function automatic int writable(input int c);
        return (c == 3 || c == 4 || c == 5) ? 0 : 1;
    endfunction

    task automatic cyc(input logic e, input logic c, input logic w, input logic [15:0] d,
                       input string req);
        int   cw, cr, arl, srs;
        exp_t x;
        @(negedge clk);
        en_n = e; cmd_n = c; wr_n = w; bus = d;
        #5;
        cw = (!e && !c && !w) ? 1 : 0;
        cr = (!e && !c && w) ? 1 : 0;
        chk(req, "stat_rd", stat_rd, cr & (m_pend ^ 1));
        chk(req, "reg_rd", reg_rd, cr & m_pend);
        chk(req, "reg_wr", reg_wr, cw & m_pend & writable(m_code));
        chk(req, "id_oe", id_oe, (cr && m_pend && m_code == 4) ? 1 : 0);
        if (m_pend && (cw || cr)) chk(req, "reg_code", reg_code, m_code);
        arl = 0; srs = 0;
        if (m_pend && (cw || cr)) begin
            m_pend = 0;
            if (cw && m_code == 0 && d == 16'h0000) begin
                srs = 1;
                model_reset();
            end
        end else if (cw) begin
            if (m_wait) begin
                if (m_wdst) begin m_dst = m_hdst; m_msk = m_hmsk; m_vld = m_hvld; end
                else m_src = m_hsrc;
                arl = 1; m_arv = d[11:0]; m_wait = 0;
            end else if (d[15:12] == 4'h0) begin
                if (d[10:8] == 3'b000 && d[7:3] == 5'd0) begin
                    if (d[11] && d[2:0] == 3'd3) begin m_wait = 1; m_wdst = 0; m_hsrc = 3; end
                    else m_src = d[2:0];
                end else if (d[10:8] == 3'b001) begin
                    if (d[11] && d[5:3] == 3'd3) begin
                        m_wait = 1; m_wdst = 1; m_hdst = 3; m_hmsk = d[7:6]; m_hvld = d[2:0];
                    end else begin
                        m_dst = d[5:3]; m_msk = d[7:6]; m_vld = d[2:0];
                    end
                end else if (d[10:8] == 3'b010 && !d[11] && d[7:6] == 2'b00 && d[2:0] == 3'b000) begin
                    m_pend = 1; m_code = d[5:3];
                end
            end
        end
        x.src = m_src; x.dst = m_dst; x.msk = m_msk; x.vld = m_vld;
        x.arl = arl; x.arv = m_arv; x.srs = srs; x.req = req;
        q.push_back(x);
    endtask

    // monitor: compares registered outputs one edge after each driven cycle
    initial begin
        forever begin
            exp_t x;
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                x = q.pop_front();
                chk(x.req, "src_sel", src_sel, x.src);
                chk(x.req, "dst_sel", dst_sel, x.dst);
                chk(x.req, "dst_mask", dst_mask, x.msk);
                chk(x.req, "dst_valid", dst_valid, x.vld);
                chk(x.req, "ar_load", ar_load, x.arl);
                chk(x.req, "ar_value", ar_value, x.arv);
                chk(x.req, "soft_rst", soft_rst, x.srs);
            end
        end
    end

    initial begin
        #4000000;
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; en_n = 1'b1; cmd_n = 1'b1; wr_n = 1'b1; bus = 16'h0000;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1 reset state
        chk("R1", "src_sel", src_sel, 0);
        chk("R1", "dst_sel", dst_sel, 0);
        chk("R1", "dst_mask", dst_mask, 0);
        chk("R1", "dst_valid", dst_valid, 0);
        chk("R1", "ar_load", ar_load, 0);
        chk("R1", "soft_rst", soft_rst, 0);

        cyc(0, 0, 1, 16'h0000, "R2");          // plain status read
        cyc(1, 0, 0, 16'h0002, "R10");         // enable high: ignored
        cyc(0, 1, 0, 16'h0002, "R10");         // data write: ignored
        cyc(0, 0, 0, 16'h0002, "R3");          // source = 2
        cyc(0, 1, 1, 16'h0000, "R3");          // data read keeps it
        cyc(0, 0, 0, 16'h018D, "R4");          // dst=1 mask=2 valid=5
        cyc(0, 0, 0, 16'h0801, "R3");          // flag with non-memory: immediate
        cyc(0, 0, 0, 16'h0803, "R5");          // source memory at address: wait
        cyc(0, 0, 1, 16'h0000, "R5");          // status read does not consume
        cyc(0, 1, 0, 16'h1111, "R5");          // data write does not consume
        cyc(0, 0, 0, 16'h0ABC, "R5");          // address arrives
        cyc(0, 0, 0, 16'h095B, "R5");          // dst memory at address, mask 1, valid 3
        cyc(0, 0, 0, 16'hFFFF, "R5");          // address 0xFFF
        cyc(0, 0, 0, 16'h0003, "R3");          // memory at current address: no load
        cyc(0, 0, 0, 16'h0803, "R5");          // wait again
        cyc(0, 0, 0, 16'h0230, "R5");          // override-looking word taken as address
        cyc(0, 0, 1, 16'h0000, "R5");          // nothing armed: status
        cyc(0, 0, 0, 16'h1234, "R10");         // unknown opcodes
        cyc(0, 0, 0, 16'h0300, "R10");
        cyc(0, 0, 0, 16'h0012, "R10");
        cyc(0, 0, 0, 16'h0231, "R10");         // malformed override
        cyc(0, 0, 1, 16'h0000, "R10");
        cyc(0, 0, 0, 16'h0230, "R6");          // arm override to code 6
        cyc(0, 1, 1, 16'h0000, "R6");          // data read keeps it pending
        cyc(0, 0, 0, 16'h0002, "R6");          // routed write, not decoded
        cyc(0, 0, 1, 16'h0000, "R6");          // reverted to status
        cyc(0, 0, 0, 16'h0210, "R6");          // arm code 2
        cyc(0, 0, 1, 16'h0000, "R6");          // routed read
        cyc(0, 0, 0, 16'h0218, "R7");          // code 3 write blocked
        cyc(0, 0, 0, 16'h0005, "R7");
        cyc(0, 0, 0, 16'h0220, "R7");          // code 4 write blocked
        cyc(0, 0, 0, 16'h0001, "R7");
        cyc(0, 0, 0, 16'h0228, "R7");          // code 5 write of zero blocked
        cyc(0, 0, 0, 16'h0000, "R7");
        cyc(0, 0, 0, 16'h0006, "R7");          // decoder active again
        cyc(0, 0, 0, 16'h0220, "R8");          // arm code 4
        cyc(0, 0, 1, 16'h0000, "R8");          // identifier read
        chk("R8", "id_value", id_value, 12'hC47);
        cyc(0, 0, 0, 16'h0200, "R9");          // control, nonzero write
        cyc(0, 0, 0, 16'h0001, "R9");
        cyc(0, 0, 0, 16'h0200, "R9");          // control, zero write
        cyc(0, 0, 0, 16'h0000, "R9");
        cyc(0, 0, 1, 16'h0000, "R9");
        cyc(1, 1, 1, 16'h0000, "R10");
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule